// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns a 32-bit virtual address into a 32-bit physical address by consulting a single flat page table in memory. A requester presents a virtual address and an access kind (load, store or instruction fetch). The block computes where the table entry for that virtual page sits, reads the entry over a plain request/acknowledge memory port, and checks the entry's valid flag and its permission flags against the access kind. It then answers with either a physical address or a fault code. When a successful access has to set the entry's referenced or modified flag, the block writes the updated entry back to the same location before it answers.

Software sets the table location through a load strobe and a data word. Pages are 4 KiB. The upper 20 bits of the virtual address select one 4-byte entry, and the low 12 bits pass through unchanged. Only one translation is handled at a time. The requester waits for the ready flag before it issues the next request.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. `req_ready` goes low at the clock edge that accepts a request and stays low up to and including the response cycle.
- R2: Each translation issues exactly one entry read (`mem_we`=0). Its word address is table base + 4 × (virtual address bits [31:12]).
- R3: For a successful access, `rsp_paddr` is entry bits [31:12] followed by virtual address bits [11:0]. For example, virtual 0x13325328 with entry frame 0x03004 gives 0x03004328.
- R4: If entry bit 0 (valid) is 0, the response carries fault code 1 and `rsp_paddr` is 0, and no write reaches memory.
- R5: `req_kind` 00 is a load and needs entry bit 3. Code 01 is a store and needs entry bit 4. Codes 10 and 11 are a fetch and need entry bit 5. If a valid entry lacks the needed bit, the response carries fault code 2, `rsp_paddr` is 0, and nothing is written.
- R6: A successful access sets entry bit 1 (referenced). A successful store also sets entry bit 2 (modified). All other entry bits are kept. The updated entry is written back to the address that was read, and only when its value differs from the value read.
- R7: `rsp_valid` is high for exactly one cycle per translation. Fault code 0 marks success, and code 3 never appears.
- R8: A pulse on `base_load` loads `base_value` as the table base, with its low 12 bits forced to zero. A request accepted in the same cycle as a base load still uses the previous base. Later requests use the new base.
- R9: `mem_req` stays high with a stable address, write flag and write data until `mem_ack` arrives. The memory may take any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_load | input | 1 | Load strobe for the table base |
| base_value | input | 32 | New table base; low 12 bits ignored |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid entry, 2 permission |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |

## Verification
Two events can land on the same clock edge: a table-base load and the acceptance of a request. The bench raises `base_load` and `req_valid` in the same cycle. It then checks that the entry read goes to the old base, and that the following translation reads from the new base with the new base's low bits discarded. The main sweep covers every combination of the six entry flags with all three access kinds, and varies the memory wait cycles. For each run, the bench computes from the entry and the access kind the expected fault code, the physical address, and whether a write-back occurs and what value it carries.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  // access kinds as presented on req_kind (bit 1 set means fetch)
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;

  // fault codes
  localparam logic [1:0] FLT_NONE    = 2'd0;
  localparam logic [1:0] FLT_INVALID = 2'd1;
  localparam logic [1:0] FLT_PERM    = 2'd2;

  // entry flag positions
  localparam int BIT_VALID = 0;
  localparam int BIT_REF   = 1;
  localparam int BIT_MOD   = 2;
  localparam int BIT_CAN_LD = 3;
  localparam int BIT_CAN_ST = 4;
  localparam int BIT_CAN_EX = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBACK,
    ST_ANSWER
  } walk_state_e;
endpackage

// File: rtl/vpx_base_reg.sv
module vpx_base_reg #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] value,
  output logic [AW-1:0] base_q
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << PAGE_BITS) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= value & ~LOW_MASK;
  end
endmodule

// File: rtl/vpx_entry_chk.sv
module vpx_entry_chk
  import vpx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0]        entry,
  input  logic [1:0]           kind,
  input  logic [PAGE_BITS-1:0] offset,
  output logic [1:0]           fault,
  output logic [AW-1:0]        paddr,
  output logic [AW-1:0]        new_entry,
  output logic                 need_wb
);
  logic allowed;

  always_comb begin
    unique case (kind)
      KIND_LOAD:  allowed = entry[BIT_CAN_LD];
      KIND_STORE: allowed = entry[BIT_CAN_ST];
      default:    allowed = entry[BIT_CAN_EX];
    endcase

    if (!entry[BIT_VALID]) fault = FLT_INVALID;
    else if (!allowed)     fault = FLT_PERM;
    else                   fault = FLT_NONE;

    paddr = {entry[AW-1:PAGE_BITS], offset};

    new_entry = entry;
    new_entry[BIT_REF] = 1'b1;
    if (kind == KIND_STORE) new_entry[BIT_MOD] = 1'b1;

    need_wb = (fault == FLT_NONE) && (new_entry != entry);
  end
endmodule

// File: rtl/vpx_ctrl.sv
module vpx_ctrl
  import vpx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        base_q,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_vaddr,
  input  logic [1:0]           req_kind,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [AW-1:0]        mem_wdata,
  input  logic                 mem_ack,
  output logic [PAGE_BITS-1:0] chk_offset,
  output logic [1:0]           chk_kind,
  input  logic [1:0]           chk_fault,
  input  logic [AW-1:0]        chk_paddr,
  input  logic [AW-1:0]        chk_new,
  input  logic                 chk_wb,
  output logic                 rsp_valid,
  output logic [AW-1:0]        rsp_paddr,
  output logic [1:0]           rsp_fault
);
  localparam int VPN_W = AW - PAGE_BITS;

  walk_state_e         state_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [1:0]           kind_q;
  logic [AW-1:0]        addr_q;
  logic [AW-1:0]        wdata_q;
  logic [AW-1:0]        paddr_q;
  logic [1:0]           fault_q;
  logic [VPN_W-1:0]     vpn;

  assign vpn = req_vaddr[AW-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          off_q   <= req_vaddr[PAGE_BITS-1:0];
          kind_q  <= req_kind;
          addr_q  <= base_q + (AW'(vpn) << PTE_SHIFT);
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          fault_q <= chk_fault;
          paddr_q <= (chk_fault == FLT_NONE) ? chk_paddr : '0;
          wdata_q <= chk_new;
          state_q <= chk_wb ? ST_WBACK : ST_ANSWER;
        end
        ST_WBACK: if (mem_ack) state_q <= ST_ANSWER;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_WBACK);
  assign mem_we     = (state_q == ST_WBACK);
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rsp_valid  = (state_q == ST_ANSWER);
  assign rsp_paddr  = paddr_q;
  assign rsp_fault  = fault_q;
  assign chk_offset = off_q;
  assign chk_kind   = kind_q;

  AST_BUSY_WHILE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready); // R1
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[PTE_SHIFT-1:0] == '0)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0)); // R4
  AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[BIT_REF] && mem_wdata[BIT_VALID])); // R6
  AST_ANSWER_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault != 2'd3)); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R9
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_load,
  input  logic [AW-1:0] base_value,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_fault,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  logic [AW-1:0]        base_q;
  logic [PAGE_BITS-1:0] chk_offset;
  logic [1:0]           chk_kind;
  logic [1:0]           chk_fault;
  logic [AW-1:0]        chk_paddr;
  logic [AW-1:0]        chk_new;
  logic                 chk_wb;

  vpx_base_reg #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_base (
    .clk(clk), .rst(rst), .load(base_load), .value(base_value), .base_q(base_q)
  );

  vpx_entry_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
    .entry(mem_rdata), .kind(chk_kind), .offset(chk_offset),
    .fault(chk_fault), .paddr(chk_paddr), .new_entry(chk_new), .need_wb(chk_wb)
  );

  vpx_ctrl #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PTE_SHIFT(PTE_SHIFT)) u_ctrl (
    .clk(clk), .rst(rst), .base_q(base_q),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .chk_offset(chk_offset), .chk_kind(chk_kind), .chk_fault(chk_fault),
    .chk_paddr(chk_paddr), .chk_new(chk_new), .chk_wb(chk_wb),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );
endmodule

// File: tb/vpage_xlate_test.sv
`timescale 1ns/1ps
module vpage_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_load = 1'b0;
  logic [31:0] base_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  vpage_xlate uut (
    .clk(clk), .rst(rst), .base_load(base_load), .base_value(base_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model: 1024 words indexed by address bits [11:2], configurable wait
  logic [31:0] mem [0:1023];
  int          lat = 0;
  int          wcnt = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wcnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[11:2]];
          rd_cnt <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected outcome computed from the requirement text
  task automatic predict(input logic [31:0] ent, input logic [1:0] kind,
                         input logic [11:0] off, output logic [1:0] flt,
                         output logic [31:0] pa, output bit wb,
                         output logic [31:0] nent);
    bit perm;
    perm = (kind == 2'd0) ? ent[3] : (kind == 2'd1) ? ent[4] : ent[5];
    nent = ent;
    wb = 1'b0;
    if (!ent[0]) begin flt = 2'd1; pa = '0; end
    else if (!perm) begin flt = 2'd2; pa = '0; end
    else begin
      flt = 2'd0;
      pa = {ent[31:12], off};
      nent = ent | 32'h2 | ((kind == 2'd1) ? 32'h4 : 32'h0);
      wb = (nent != ent);
    end
  endtask

  logic [1:0]  got_flt;
  logic [31:0] got_pa;

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind,
                       input bit load_base, input logic [31:0] newbase);
    while (!req_ready) @(negedge clk);
    req_vaddr = va;
    req_kind = kind;
    req_valid = 1'b1;
    base_load = load_base;
    base_value = newbase;
    @(negedge clk);
    req_valid = 1'b0;
    base_load = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low after accept", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    got_flt = rsp_fault;
    got_pa = rsp_paddr;
    chk(req_ready == 1'b0, "R1 ready low in answer cycle", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 one-cycle response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic run_one(input logic [31:0] base, input logic [19:0] vpn,
                         input logic [11:0] off, input logic [31:0] ent,
                         input logic [1:0] kind);
    logic [1:0]  eflt;
    logic [31:0] epa, nent;
    bit          ewb;
    int          rd0, wr0;
    predict(ent, kind, off, eflt, epa, ewb, nent);
    mem[vpn[9:0]] = ent;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    xlate({vpn, off}, kind, 1'b0, '0);
    chk(rd_cnt - rd0 == 1, "R2 single entry read", 32'(rd_cnt - rd0), 32'd1);
    chk(last_rd_addr == base + {10'd0, vpn, 2'b00}, "R2 entry address",
        last_rd_addr, base + {10'd0, vpn, 2'b00});
    chk(got_flt == eflt, (eflt == 2'd1) ? "R4 invalid code" :
        (eflt == 2'd2) ? "R5 permission code" : "R7 success code",
        {30'd0, got_flt}, {30'd0, eflt});
    chk(got_pa == epa, (eflt == 2'd0) ? "R3 physical address" : "R4/R5 zero address",
        got_pa, epa);
    chk(wr_cnt - wr0 == (ewb ? 1 : 0), "R6 write-back count",
        32'(wr_cnt - wr0), ewb ? 32'd1 : 32'd0);
    chk(mem[vpn[9:0]] == nent, "R6 entry after access", mem[vpn[9:0]], nent);
    if (ewb) chk(last_wr_addr == last_rd_addr, "R6 write-back address",
                 last_wr_addr, last_rd_addr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] base_a, base_b, ent;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
    chk(mem_req == 1'b0, "R1 no memory request after reset", {31'd0, mem_req}, 32'd0);

    // R8: load base through the port, low bits discarded
    base_a = 32'h0040_0000;
    base_value = base_a | 32'h0000_0ABC;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;

    // R3 worked example
    run_one(base_a, 20'h13325, 12'h328, 32'h0300_4009, 2'd0);

    // R9 sweep with wait states; all 64 flag patterns x 3 kinds
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 3; k++) begin
        lat = (i + k) % 3;
        ent = {20'hC0000 ^ 20'(i * 37), 6'd0, 6'(i)};
        run_one(base_a, 20'h5A000 | 20'(i), 12'((i * 13 + k * 101) & 12'hFFF),
                ent, 2'(k));
      end
    end
    lat = 1;

    // R5: kind 11 acts as fetch
    run_one(base_a, 20'h5A07F, 12'h010, 32'h1234_5021, 2'd3); // exec-only valid
    run_one(base_a, 20'h5A07E, 12'h020, 32'h1234_5019, 2'd3); // no exec bit

    // R8: base load in the same cycle as request acceptance
    base_b = 32'h0080_3000;
    mem[10'h3C0] = 32'hABCD_E00B;
    xlate({20'h5A3C0, 12'h444}, 2'd0, 1'b1, base_b | 32'h0000_0FFF);
    chk(last_rd_addr == base_a + {10'd0, 20'h5A3C0, 2'b00}, "R8 old base used",
        last_rd_addr, base_a + {10'd0, 20'h5A3C0, 2'b00});
    chk(got_pa == 32'hABCD_E444, "R3 address at base switch", got_pa, 32'hABCD_E444);
    run_one(base_b, 20'h5A3C1, 12'h555, 32'h7777_7019, 2'd1);

    // second sweep under the new base, store kind, no wait
    lat = 0;
    for (int i = 0; i < 64; i++) begin
      ent = {20'h0F0F0 ^ 20'(i * 11), 6'd0, 6'(i)};
      run_one(base_b, 20'h5A000 | 20'(i), 12'(i * 61), ent, 2'd1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule